// File: doc/BRIEF.md
# BAR-Steered Dual Memory Request Handler

This block sits behind the receive side of a PCIe endpoint and serves single-DWORD memory requests. The requests arrive already decoded. Each request comes with active-low hit flags, one per base address register. The block uses these flags to pick one of two on-chip memories. It discards the upper address bits and indexes the chosen memory with the word offset inside its 4 KB window. A write stores its data there. A read fetches the addressed word one cycle later and presents a completion record with the request tag, the requester ID and the data. The record stays on the transmit-side interface until the transmit side accepts it. No new request is taken in the meantime.

Each memory also has an independent second port for a local agent, such as a serial-link loopback path that fills one window and drains the other. That agent can read and write at the same time as the request path.

Top module: `bar_mem_router`

## Requirements
- R1: After reset, `cpl_valid_o` and `err_o` are low and `req_ready_o` is high.
- R2: `req_bar_hit_ni` is active low. Bit 0 low (value 2'b10) selects memory 0 and bit 1 low (value 2'b01) selects memory 1. An accepted write stores `req_data_i` at word offset `req_addr_i[11:2]` of the selected memory.
- R3: An accepted read raises `cpl_valid_o` in the cycle after the accepting edge. The completion carries the request's tag, the requester ID and the stored word.
- R4: Address bits [31:12] and [1:0] have no effect on which word is accessed.
- R5: A request whose hit flags are 2'b11 or 2'b00 is dropped. It writes nothing, produces no completion, and raises `err_o` for the single cycle after the accepting edge.
- R6: While `cpl_valid_o` is high and `cpl_ready_i` is low, the completion fields stay unchanged and `req_ready_o` stays low. The completion clears one edge after `cpl_ready_i` is seen high.
- R7: Each local port reads with one cycle of latency and writes at its clock edge. Data written on one side (request or local) is visible from the other.
- R8: The two windows are independent. The same offset in each memory holds separate data.
- R9: If the request path and a local port write the same word on the same edge, the request data is kept.
- R10: An accepted write produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request intake open |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_bar_hit_ni | input | 2 | Per-BAR hit flags, active low |
| req_addr_i | input | 32 | Byte address |
| req_data_i | input | 32 | Write data |
| req_tag_i | input | 8 | Request tag |
| req_rid_i | input | 16 | Requester ID |
| cpl_valid_o | output | 1 | Completion present |
| cpl_ready_i | input | 1 | Transmit side accepts completion |
| cpl_tag_o | output | 8 | Completion tag |
| cpl_rid_o | output | 16 | Completion requester ID |
| cpl_data_o | output | 32 | Completion data |
| err_o | output | 1 | Dropped-request strobe |
| loc_en_i | input | 2 | Local port enable, one per memory |
| loc_we_i | input | 2 | Local port write, one per memory |
| loc_addr_i | input | 2x10 | Local word offset, one per memory |
| loc_wdata_i | input | 2x32 | Local write data, one per memory |
| loc_rdata_o | output | 2x32 | Local read data, one per memory |

## Verification
A write updates memory at the edge that accepts it. The completion for a read and the error strobe for a dropped request appear one edge after acceptance. Local read data appears one edge after the local enable is sampled. The bench drives every input at the falling edge, lets exactly one rising edge pass, and samples at the next falling edge. Each result is therefore read in the cycle it is due. Held completions are sampled again on each later falling edge until the release edge. Stale-data checks read the word back through the request path or the local port.

// File: rtl/bar_mem_pkg.sv
package bar_mem_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TAG_W  = 8;
  localparam int unsigned RID_W  = 16;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [RID_W-1:0]  rid_t;
endpackage

// File: rtl/bmr_dpram.sv
module bmr_dpram #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          a_en_i,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_wdata_i,
  output logic [DW-1:0] a_rdata_o,
  input  logic          b_en_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_wdata_i,
  output logic [DW-1:0] b_rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // port a written last so it wins a same-word collision
  always_ff @(posedge clk_i) begin
    if (b_en_i) begin
      b_rdata_o <= mem_q[b_addr_i];
      if (b_we_i) mem_q[b_addr_i] <= b_wdata_i;
    end
    if (a_en_i) begin
      a_rdata_o <= mem_q[a_addr_i];
      if (a_we_i) mem_q[a_addr_i] <= a_wdata_i;
    end
  end
endmodule

// File: rtl/bmr_decode.sv
module bmr_decode #(
  parameter int unsigned NUM_BAR = 2,
  localparam int unsigned SEL_W  = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1
) (
  input  logic [NUM_BAR-1:0] hit_ni,
  output logic [SEL_W-1:0]   sel_o,
  output logic               ok_o
);
  always_comb begin
    sel_o = '0;
    for (int i = 0; i < NUM_BAR; i++) begin
      if (!hit_ni[i]) sel_o = SEL_W'(i);
    end
  end

  assign ok_o = $onehot(~hit_ni);
endmodule

// File: rtl/bmr_cpl.sv
module bmr_cpl
  import bar_mem_pkg::*;
#(
  parameter int unsigned NUM_BAR = 2,
  localparam int unsigned SEL_W  = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fire_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  tag_t                 tag_i,
  input  rid_t                 rid_i,
  input  word_t [NUM_BAR-1:0]  rdata_i,
  input  logic                 ready_i,
  output logic                 valid_o,
  output tag_t                 tag_o,
  output rid_t                 rid_o,
  output word_t                data_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sel_q   <= '0;
      tag_o   <= '0;
      rid_o   <= '0;
    end else if (fire_i) begin
      valid_o <= 1'b1;
      sel_q   <= sel_i;
      tag_o   <= tag_i;
      rid_o   <= rid_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end

  // ram output holds: its read port is idle while intake is stalled
  assign data_o = rdata_i[sel_q];

  // R3
  rd_to_cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> valid_o && tag_o == $past(tag_i) && rid_o == $past(rid_i));

  // R6
  cpl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o) && $stable(tag_o) && $stable(rid_o));

  // R6
  cpl_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i && !fire_i |=> !valid_o);
endmodule

// File: rtl/bar_mem_router.sv
module bar_mem_router
  import bar_mem_pkg::*;
#(
  parameter int unsigned NUM_BAR   = 2,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_BYTES = 4096,
  localparam int unsigned OFF_W    = $clog2(WIN_BYTES / 4),
  localparam int unsigned SEL_W    = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_valid_i,
  output logic                            req_ready_o,
  input  logic                            req_write_i,
  input  logic [NUM_BAR-1:0]              req_bar_hit_ni,
  input  logic [ADDR_W-1:0]               req_addr_i,
  input  logic [DATA_W-1:0]               req_data_i,
  input  logic [TAG_W-1:0]                req_tag_i,
  input  logic [RID_W-1:0]                req_rid_i,
  output logic                            cpl_valid_o,
  input  logic                            cpl_ready_i,
  output logic [TAG_W-1:0]                cpl_tag_o,
  output logic [RID_W-1:0]                cpl_rid_o,
  output logic [DATA_W-1:0]               cpl_data_o,
  output logic                            err_o,
  input  logic [NUM_BAR-1:0]              loc_en_i,
  input  logic [NUM_BAR-1:0]              loc_we_i,
  input  logic [NUM_BAR-1:0][OFF_W-1:0]   loc_addr_i,
  input  logic [NUM_BAR-1:0][DATA_W-1:0]  loc_wdata_i,
  output logic [NUM_BAR-1:0][DATA_W-1:0]  loc_rdata_o
);
  logic             accept;
  logic             hit_ok;
  logic [SEL_W-1:0] hit_sel;
  logic             rd_fire;
  logic [OFF_W-1:0] req_off;
  word_t [NUM_BAR-1:0] req_rdata;
  logic             unused_addr;

  assign req_ready_o = !cpl_valid_o;
  assign accept      = req_valid_i && req_ready_o;
  assign rd_fire     = accept && hit_ok && !req_write_i;
  assign req_off     = req_addr_i[OFF_W+1:2];
  assign unused_addr = ^{req_addr_i[ADDR_W-1:OFF_W+2], req_addr_i[1:0]};

  bmr_decode #(.NUM_BAR(NUM_BAR)) u_dec (
    .hit_ni (req_bar_hit_ni),
    .sel_o  (hit_sel),
    .ok_o   (hit_ok)
  );

  for (genvar b = 0; b < NUM_BAR; b++) begin : g_bar
    logic a_en;
    assign a_en = accept && hit_ok && (hit_sel == SEL_W'(b));

    bmr_dpram #(.DW(DATA_W), .AW(OFF_W)) u_ram (
      .clk_i     (clk_i),
      .a_en_i    (a_en),
      .a_we_i    (req_write_i),
      .a_addr_i  (req_off),
      .a_wdata_i (req_data_i),
      .a_rdata_o (req_rdata[b]),
      .b_en_i    (loc_en_i[b]),
      .b_we_i    (loc_we_i[b]),
      .b_addr_i  (loc_addr_i[b]),
      .b_wdata_i (loc_wdata_i[b]),
      .b_rdata_o (loc_rdata_o[b])
    );
  end

  bmr_cpl #(.NUM_BAR(NUM_BAR)) u_cpl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (rd_fire),
    .sel_i   (hit_sel),
    .tag_i   (req_tag_i),
    .rid_i   (req_rid_i),
    .rdata_i (req_rdata),
    .ready_i (cpl_ready_i),
    .valid_o (cpl_valid_o),
    .tag_o   (cpl_tag_o),
    .rid_o   (cpl_rid_o),
    .data_o  (cpl_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= accept && !hit_ok;
  end

  // R5
  bad_hit_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && !$onehot(~req_bar_hit_ni) |=> err_o && !cpl_valid_o);

  // R5
  err_no_cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !cpl_valid_o);

  // R10
  wr_no_cpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_write_i |=> !cpl_valid_o);

  // R6
  stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_valid_o && !cpl_ready_i |=> !req_ready_o);
endmodule

// File: tb/tb_bar_mem_router.sv
module tb_bar_mem_router;
  localparam int NB = 2;
  localparam int OW = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [1:0]  req_bar_hit_ni = 2'b11;
  logic [31:0] req_addr_i = '0, req_data_i = '0;
  logic [7:0]  req_tag_i = '0;
  logic [15:0] req_rid_i = '0;
  logic cpl_ready_i = 1'b0;
  logic [NB-1:0] loc_en_i = '0, loc_we_i = '0;
  logic [NB-1:0][OW-1:0] loc_addr_i = '0;
  logic [NB-1:0][31:0]   loc_wdata_i = '0;
  logic [NB-1:0][31:0]   loc_rdata_o;
  logic req_ready_o, cpl_valid_o, err_o;
  logic [7:0]  cpl_tag_o;
  logic [15:0] cpl_rid_o;
  logic [31:0] cpl_data_o;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bar_mem_router dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_write_i(req_write_i),
    .req_bar_hit_ni(req_bar_hit_ni), .req_addr_i(req_addr_i), .req_data_i(req_data_i),
    .req_tag_i(req_tag_i), .req_rid_i(req_rid_i),
    .cpl_valid_o(cpl_valid_o), .cpl_ready_i(cpl_ready_i), .cpl_tag_o(cpl_tag_o),
    .cpl_rid_o(cpl_rid_o), .cpl_data_o(cpl_data_o), .err_o(err_o),
    .loc_en_i(loc_en_i), .loc_we_i(loc_we_i), .loc_addr_i(loc_addr_i),
    .loc_wdata_i(loc_wdata_i), .loc_rdata_o(loc_rdata_o)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] hit, input logic [31:0] addr, input logic [31:0] data);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_bar_hit_ni = hit;
    req_addr_i = addr; req_data_i = data;
    @(posedge clk); @(negedge clk);
    req_valid_i = 1'b0;
    check(cpl_valid_o == 1'b0, "R10 write gave completion", 32'(cpl_valid_o), 32'h0);
  endtask

  task automatic do_rd(input logic [1:0] hit, input logic [31:0] addr, input logic [7:0] tag,
                       input logic [15:0] rid, input logic [31:0] exp, input int hold, input string req);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_bar_hit_ni = hit;
    req_addr_i = addr; req_tag_i = tag; req_rid_i = rid;
    @(posedge clk); @(negedge clk);
    req_valid_i = 1'b0;
    check(cpl_valid_o == 1'b1, "R3 completion valid", 32'(cpl_valid_o), 32'h1);
    check(cpl_tag_o == tag && cpl_rid_o == rid, "R3 tag/rid", {cpl_tag_o, 8'h0, cpl_rid_o},
          {tag, 8'h0, rid});
    check(cpl_data_o == exp, req, cpl_data_o, exp);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(cpl_valid_o && !req_ready_o && cpl_data_o == exp && cpl_tag_o == tag,
            "R6 completion held", cpl_data_o, exp);
    end
    cpl_ready_i = 1'b1;
    @(posedge clk); @(negedge clk);
    cpl_ready_i = 1'b0;
    check(!cpl_valid_o && req_ready_o, "R6 completion released", 32'(cpl_valid_o), 32'h0);
  endtask

  task automatic loc_rd(input int b, input logic [OW-1:0] off, input logic [31:0] exp, input string req);
    loc_en_i[b] = 1'b1; loc_we_i[b] = 1'b0; loc_addr_i[b] = off;
    @(posedge clk); @(negedge clk);
    loc_en_i[b] = 1'b0;
    check(loc_rdata_o[b] == exp, req, loc_rdata_o[b], exp);
  endtask

  task automatic loc_wr(input int b, input logic [OW-1:0] off, input logic [31:0] data);
    loc_en_i[b] = 1'b1; loc_we_i[b] = 1'b1; loc_addr_i[b] = off; loc_wdata_i[b] = data;
    @(posedge clk); @(negedge clk);
    loc_en_i[b] = 1'b0; loc_we_i[b] = 1'b0;
  endtask

  task automatic t_reset();
    check(!cpl_valid_o && !err_o && req_ready_o, "R1 reset state",
          {29'h0, cpl_valid_o, err_o, req_ready_o}, 32'h1);
  endtask

  task automatic t_basic();
    do_wr(2'b10, 32'h0000_0010, 32'hA5A5_0001);
    do_wr(2'b01, 32'h0000_0010, 32'h5A5A_0002);
    do_rd(2'b10, 32'h0000_0010, 8'h11, 16'h0101, 32'hA5A5_0001, 0, "R2 BAR0 data");
    do_rd(2'b01, 32'h0000_0010, 8'h22, 16'h0202, 32'h5A5A_0002, 0, "R8 BAR1 separate data");
    do_wr(2'b10, 32'h0000_0FFC, 32'hDEAD_BEEF);
    do_rd(2'b10, 32'h0000_0FFC, 8'h33, 16'hFFFF, 32'hDEAD_BEEF, 0, "R2 top word");
  endtask

  task automatic t_upper();
    do_wr(2'b01, 32'hFFFF_F023, 32'h1234_5678);
    do_rd(2'b01, 32'h0000_0020, 8'h44, 16'h0404, 32'h1234_5678, 0, "R4 upper/low bits ignored");
    do_rd(2'b01, 32'h8765_4022, 8'h45, 16'h0405, 32'h1234_5678, 0, "R4 alias read");
  endtask

  task automatic t_hold();
    do_rd(2'b10, 32'h0000_0010, 8'h55, 16'h0A0B, 32'hA5A5_0001, 4, "R6 held read data");
  endtask

  task automatic t_bad();
    for (int k = 0; k < 2; k++) begin
      req_valid_i = 1'b1; req_write_i = 1'b1; req_bar_hit_ni = (k == 0) ? 2'b11 : 2'b00;
      req_addr_i = 32'h0000_0010; req_data_i = 32'hBAD0_BAD0;
      @(posedge clk); @(negedge clk);
      req_valid_i = 1'b0;
      check(err_o && !cpl_valid_o, "R5 error strobe", {30'h0, err_o, cpl_valid_o}, 32'h2);
      @(negedge clk);
      check(!err_o, "R5 strobe one cycle", 32'(err_o), 32'h0);
    end
    req_valid_i = 1'b1; req_write_i = 1'b0; req_bar_hit_ni = 2'b11; req_addr_i = 32'h10;
    @(posedge clk); @(negedge clk);
    req_valid_i = 1'b0;
    check(err_o && !cpl_valid_o, "R5 bad read dropped", {30'h0, err_o, cpl_valid_o}, 32'h2);
    @(negedge clk);
    check(!cpl_valid_o, "R5 no late completion", 32'(cpl_valid_o), 32'h0);
    do_rd(2'b10, 32'h10, 8'h66, 16'h0606, 32'hA5A5_0001, 0, "R5 BAR0 untouched");
    do_rd(2'b01, 32'h10, 8'h67, 16'h0607, 32'h5A5A_0002, 0, "R5 BAR1 untouched");
  endtask

  task automatic t_local();
    loc_rd(0, 10'h004, 32'hA5A5_0001, "R7 local sees request write");
    loc_rd(1, 10'h008, 32'h1234_5678, "R7 local BAR1 read");
    loc_wr(1, 10'h100, 32'hCAFE_F00D);
    do_rd(2'b01, 32'h0000_0400, 8'h77, 16'h0707, 32'hCAFE_F00D, 0, "R7 request sees local write");
    loc_rd(0, 10'h100, 32'h0, "R8 local write stays in BAR1");
  endtask

  task automatic t_collide();
    do_wr(2'b10, 32'h0000_0200, 32'h0);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_bar_hit_ni = 2'b10;
    req_addr_i = 32'h0000_0200; req_data_i = 32'h1111_2222;
    loc_en_i[0] = 1'b1; loc_we_i[0] = 1'b1; loc_addr_i[0] = 10'h080; loc_wdata_i[0] = 32'h3333_4444;
    @(posedge clk); @(negedge clk);
    req_valid_i = 1'b0; loc_en_i[0] = 1'b0; loc_we_i[0] = 1'b0;
    loc_rd(0, 10'h080, 32'h1111_2222, "R9 request wins collision");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_upper();
    t_hold();
    t_bad();
    t_local();
    t_collide();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule